// File: doc/BRIEF.md
# UART Modem Control and Interrupt Gating Stage

This block is the per-channel modem-handshake and interrupt-output stage of a multi-channel serial controller. A host processor reaches three registers through a byte-wide bus with a 3-bit address and active-low read and write strobes. The registers are an interrupt-enable register, a modem-control register and a modem-status register. The control register sets the active-low terminal-ready and request-to-send outputs, gates the channel interrupt pin, and selects an internal loopback path.

The two modem inputs, data-set-ready and ring indicator, are both active low. Each is synchronized and watched for edges. A detected edge sets a sticky change flag. A read of the status register clears that flag, and the flags can raise a modem-status interrupt condition. Three further interrupt conditions arrive from the rest of the channel. The block combines them with the enables and drives the interrupt value and the enable of its three-state buffer as two plain signals. A global select input can force that buffer on. In loopback, the transmit line replaces the external receive pin on the receive path. The modem levels are then taken from control bits.

Top module: `uart_mdm_ctl`

## Requirements
- R1: Control register (address 4) bit 0 set to 1 drives `dtr_n_o` low. Bit 0 cleared to 0 drives `dtr_n_o` high, and so does reset.
- R2: Control register bit 1 set to 1 drives `rts_n_o` low. Bit 1 cleared to 0 drives `rts_n_o` high, and so does reset.
- R3: A register write commits only after `wr_n` returns high. Holding `wr_n` low changes nothing. A write to an unmapped address leaves every register unchanged. Reading address 4 returns the control bits in [4:0], and reading address 1 returns the enable bits in [3:0].
- R4: `irq_o` is 1 only when `irq_oe_o` is 1 and an enabled condition exists. Enable bits at address 1 map as follows: bit 0 enables `cond_i[0]` (receive data), bit 1 enables `cond_i[1]` (transmit empty), and bit 2 enables `cond_i[2]` (line error).
- R5: `irq_oe_o` is 1 whenever `int_sel_i` is 1. When `int_sel_i` is 0, `irq_oe_o` equals control bit 3.
- R6: After reset, all registers read 0, `irq_oe_o` is 0 with `int_sel_i` low, `irq_o` is 0, and `dtr_n_o` and `rts_n_o` are both high.
- R7: When control bit 4 (loopback) is 1, `rx_core_o` follows `tx_i` and ignores `rx_pin_i`. When bit 4 is 0, `rx_core_o` follows `rx_pin_i`.
- R8: Status register (address 6) bit 4 reports the data-set-ready level as active-high, and bit 5 reports the ring level the same way. Outside loopback both are the inverted, synchronized pins. In loopback, bit 4 equals control bit 0 and bit 5 equals control bit 2, and the pins are ignored.
- R9: Status bit 0 becomes 1 on any change of the data-set-ready level. Status bit 1 becomes 1 only when the ring level falls from active to inactive, which is `ri_n_i` going low to high. Both flags hold until the status register is read, meaning `rd_n` returns high while the address is 6.
- R10: With enable bit 3 set, either status change flag is a modem-status interrupt condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| dsr_n_i | input | 1 | Data-set-ready, active low |
| ri_n_i | input | 1 | Ring indicator, active low |
| dtr_n_o | output | 1 | Terminal-ready, active low |
| rts_n_o | output | 1 | Request-to-send, active low |
| int_sel_i | input | 1 | Global override forcing the interrupt buffer on |
| cond_i | input | 3 | Channel interrupt conditions (receive data, transmit empty, line error) |
| irq_o | output | 1 | Interrupt value, active high |
| irq_oe_o | output | 1 | Enable of the interrupt pin's three-state buffer |
| tx_i | input | 1 | Serial transmit data from the transmitter |
| rx_pin_i | input | 1 | External serial receive pin |
| rx_core_o | output | 1 | Receive data delivered to the receiver |

## Verification
The interrupt gate is driven with each of the three conditions, each against a matching enable and against a mismatched one. Each case is tried with the buffer enabled by the control bit, by the global select alone, and by neither. These cases separate a wrong enable mapping from a wrong override. The ring input is driven through both edge directions, so that a detector firing on the wrong edge is exposed. Each flag is checked again after a wait and after a status read, which separates sticky behaviour from clear-on-read. Loopback is entered and left with pins and control bits that disagree, which shows which source feeds the receive path and the status levels.

// File: rtl/uart_mdm_pkg.sv
package uart_mdm_pkg;
   // control register layout (bit 4 down to bit 0)
   typedef struct packed {
      logic loop;
      logic irq_gate;
      logic aux_ri;
      logic rts;
      logic dtr;
   } mdm_ctl_t;

   localparam int CTL_W       = 5;
   localparam int STAT_DDSR   = 0;
   localparam int STAT_TERI   = 1;
   localparam int STAT_DSR    = 4;
   localparam int STAT_RI     = 5;
   localparam int STAT_MIN_W  = 6;
endpackage

// File: rtl/uart_mdm_sync.sv
module uart_mdm_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 1) begin : g_bad
         initial $error("uart_mdm_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (rst) chain <= RST_VAL;
            else     chain <= d;
         end
      end else begin : g_many
         always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{RST_VAL}};
            else     chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_mdm_bus.sv
module uart_mdm_bus
   import uart_mdm_pkg::*;
#(
   parameter int          ADDR_W      = 3,
   parameter int          DATA_W      = 8,
   parameter int          SYNC_STAGES = 2,
   parameter int          EN_W        = 4,
   parameter logic [ADDR_W-1:0] EN_ADDR   = 3'd1,
   parameter logic [ADDR_W-1:0] CTL_ADDR  = 3'd4,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 3'd6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_n,
   input  logic              rd_n,
   input  logic [DATA_W-1:0] stat_i,
   output mdm_ctl_t          ctl_o,
   output logic [EN_W-1:0]   en_o,
   output logic [DATA_W-1:0] rdata,
   output logic              stat_clr_o
);
   logic wr_s, rd_s, wr_q, rd_q, wr_rise, rd_rise;
   logic unused_wdata;

   generate
      if (EN_W > DATA_W || CTL_W > DATA_W) begin : g_bad
         initial $error("uart_mdm_bus: register wider than data bus");
      end
   endgenerate

   uart_mdm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wr_sync (
      .clk(clk), .rst(rst), .d(wr_n), .q(wr_s));
   uart_mdm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rd_sync (
      .clk(clk), .rst(rst), .d(rd_n), .q(rd_s));

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_q <= 1'b1;
         rd_q <= 1'b1;
      end else begin
         wr_q <= wr_s;
         rd_q <= rd_s;
      end
   end

   assign wr_rise    = wr_s & ~wr_q;
   assign rd_rise    = rd_s & ~rd_q;
   assign stat_clr_o = rd_rise && (addr == STAT_ADDR);

   always_ff @(posedge clk) begin
      if (rst) begin
         ctl_o <= '0;
         en_o  <= '0;
      end else if (wr_rise) begin
         if (addr == CTL_ADDR) ctl_o <= mdm_ctl_t'(wdata[CTL_W-1:0]);
         if (addr == EN_ADDR)  en_o  <= wdata[EN_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == CTL_ADDR)       rdata[CTL_W-1:0] = ctl_o;
      else if (addr == EN_ADDR)   rdata[EN_W-1:0]  = en_o;
      else if (addr == STAT_ADDR) rdata            = stat_i;
   end

   assign unused_wdata = ^wdata;

   // R3: registers move only on a committed write
   p_ctl_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !wr_rise |=> $stable(ctl_o));
   // R1: committed control write lands bit 0 in the terminal-ready field
   p_ctl_dtr_r1: assert property (@(posedge clk) disable iff (rst)
      (wr_rise && addr == CTL_ADDR) |=> (ctl_o.dtr == $past(wdata[0])));
endmodule

// File: rtl/uart_mdm_sense.sv
module uart_mdm_sense #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic dsr_n_i,
   input  logic ri_n_i,
   input  logic loop_i,
   input  logic lb_dsr_i,
   input  logic lb_ri_i,
   input  logic clr_i,
   output logic dsr_lvl_o,
   output logic ri_lvl_o,
   output logic ddsr_o,
   output logic teri_o
);
   logic dsr_s, ri_s, dsr_prev, ri_prev;

   uart_mdm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_dsr_sync (
      .clk(clk), .rst(rst), .d(dsr_n_i), .q(dsr_s));
   uart_mdm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ri_sync (
      .clk(clk), .rst(rst), .d(ri_n_i), .q(ri_s));

   assign dsr_lvl_o = loop_i ? lb_dsr_i : ~dsr_s;
   assign ri_lvl_o  = loop_i ? lb_ri_i  : ~ri_s;

   always_ff @(posedge clk) begin
      if (rst) begin
         dsr_prev <= 1'b0;
         ri_prev  <= 1'b0;
         ddsr_o   <= 1'b0;
         teri_o   <= 1'b0;
      end else begin
         dsr_prev <= dsr_lvl_o;
         ri_prev  <= ri_lvl_o;
         if (dsr_lvl_o != dsr_prev) ddsr_o <= 1'b1;
         else if (clr_i)            ddsr_o <= 1'b0;
         if (ri_prev && !ri_lvl_o)  teri_o <= 1'b1;
         else if (clr_i)            teri_o <= 1'b0;
      end
   end

   // R9: flags are sticky until the status read
   p_ddsr_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      (ddsr_o && !clr_i) |=> ddsr_o);
   p_teri_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      (teri_o && !clr_i) |=> teri_o);
endmodule

// File: rtl/uart_mdm_ctl.sv
module uart_mdm_ctl
   import uart_mdm_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int DATA_W      = 8,
   parameter int N_SRC       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              wr_n,
   input  logic              rd_n,
   input  logic              dsr_n_i,
   input  logic              ri_n_i,
   output logic              dtr_n_o,
   output logic              rts_n_o,
   input  logic              int_sel_i,
   input  logic [N_SRC-1:0]  cond_i,
   output logic              irq_o,
   output logic              irq_oe_o,
   input  logic              tx_i,
   input  logic              rx_pin_i,
   output logic              rx_core_o
);
   localparam int EN_W = N_SRC + 1;

   mdm_ctl_t            ctl;
   logic [EN_W-1:0]     en;
   logic [DATA_W-1:0]   stat;
   logic                stat_clr, dsr_lvl, ri_lvl, ddsr, teri;
   logic                src_pend, ms_pend;

   generate
      if (DATA_W < STAT_MIN_W) begin : g_bad_w
         initial $error("uart_mdm_ctl: DATA_W too narrow for status layout");
      end
      if (SYNC_STAGES < 2) begin : g_bad_s
         initial $error("uart_mdm_ctl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   uart_mdm_bus #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .EN_W(EN_W),
      .EN_ADDR(ADDR_W'(1)), .CTL_ADDR(ADDR_W'(4)), .STAT_ADDR(ADDR_W'(6))
   ) u_bus (
      .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_n(wr_n), .rd_n(rd_n),
      .stat_i(stat), .ctl_o(ctl), .en_o(en), .rdata(rdata), .stat_clr_o(stat_clr));

   uart_mdm_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
      .clk(clk), .rst(rst), .dsr_n_i(dsr_n_i), .ri_n_i(ri_n_i),
      .loop_i(ctl.loop), .lb_dsr_i(ctl.dtr), .lb_ri_i(ctl.aux_ri),
      .clr_i(stat_clr), .dsr_lvl_o(dsr_lvl), .ri_lvl_o(ri_lvl),
      .ddsr_o(ddsr), .teri_o(teri));

   always_comb begin
      stat            = '0;
      stat[STAT_DDSR] = ddsr;
      stat[STAT_TERI] = teri;
      stat[STAT_DSR]  = dsr_lvl;
      stat[STAT_RI]   = ri_lvl;
   end

   assign dtr_n_o   = ~ctl.dtr;
   assign rts_n_o   = ~ctl.rts;
   assign rx_core_o = ctl.loop ? tx_i : rx_pin_i;

   assign src_pend = |(cond_i & en[N_SRC-1:0]);
   assign ms_pend  = en[N_SRC] & (ddsr | teri);
   assign irq_oe_o = int_sel_i | ctl.irq_gate;
   assign irq_o    = irq_oe_o & (src_pend | ms_pend);

   // R4: no interrupt value while the buffer is off
   p_irq_needs_oe_r4: assert property (@(posedge clk) disable iff (rst)
      irq_o |-> irq_oe_o);
   // R5: global select overrides the control bit
   p_sel_forces_oe_r5: assert property (@(posedge clk) disable iff (rst)
      int_sel_i |-> irq_oe_o);
   // R6: buffer off right after reset when not overridden
   p_reset_oe_off_r6: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && !int_sel_i) |-> !irq_oe_o);
   // R10: a pending change flag with its enable and an open buffer interrupts
   p_ms_irq_r10: assert property (@(posedge clk) disable iff (rst)
      (irq_oe_o && en[N_SRC] && (ddsr || teri)) |-> irq_o);
   // R7: loopback routes the transmit line to the receiver
   p_loop_rx_r7: assert property (@(posedge clk) disable iff (rst)
      ctl.loop |-> (rx_core_o == tx_i));
endmodule

// File: tb/uart_mdm_ctl_tb.sv
module uart_mdm_ctl_tb;
   typedef struct {
      string      req;
      logic       dtr_n, rts_n, oe, irq, rx;
      logic [7:0] rd;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       wr_n = 1'b1, rd_n = 1'b1;
   logic       dsr_n = 1'b1, ri_n = 1'b1;
   logic       dtr_n, rts_n, int_sel = 1'b0, irq, irq_oe;
   logic [2:0] cond = '0;
   logic       tx = 1'b1, rx_pin = 1'b1, rx_core;

   exp_t sb_q[$];
   int   n_checks = 0, n_fail = 0;
   bit   done = 0;

   // bench model from the requirements
   logic [4:0] m_ctl = '0;
   logic [3:0] m_en  = '0;
   logic       m_ddsr = 0, m_teri = 0, m_dsr_prev = 0, m_ri_prev = 0;

   always #2 clk = ~clk;

   uart_mdm_ctl u_dut (
      .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .rdata(rdata),
      .wr_n(wr_n), .rd_n(rd_n), .dsr_n_i(dsr_n), .ri_n_i(ri_n),
      .dtr_n_o(dtr_n), .rts_n_o(rts_n), .int_sel_i(int_sel), .cond_i(cond),
      .irq_o(irq), .irq_oe_o(irq_oe), .tx_i(tx), .rx_pin_i(rx_pin),
      .rx_core_o(rx_core));

   function automatic logic m_dsr_lvl();
      return m_ctl[4] ? m_ctl[0] : ~dsr_n;
   endfunction
   function automatic logic m_ri_lvl();
      return m_ctl[4] ? m_ctl[2] : ~ri_n;
   endfunction

   task automatic track();
      logic d, r;
      d = m_dsr_lvl();
      r = m_ri_lvl();
      if (d != m_dsr_prev) m_ddsr = 1;
      if (m_ri_prev && !r) m_teri = 1;
      m_dsr_prev = d;
      m_ri_prev  = r;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_n = 1'b0;
      settle(4);
      wr_n = 1'b1;
      settle(8);
      if (a == 3'd4) m_ctl = d[4:0];
      if (a == 3'd1) m_en  = d[3:0];
      track();
   endtask

   task automatic stat_read();
      @(negedge clk);
      addr = 3'd6; rd_n = 1'b0;
      settle(4);
      rd_n = 1'b1;
      settle(8);
      m_ddsr = 0; m_teri = 0;
   endtask

   task automatic pins(input logic d, input logic r);
      @(negedge clk);
      dsr_n = d; ri_n = r;
      settle(8);
      track();
   endtask

   // driver: computes expected outputs and pushes them for the monitor
   task automatic expect_at(input string req, input logic [2:0] a);
      exp_t e;
      logic oe, pend;
      @(negedge clk);
      addr = a;
      settle(1);
      oe   = int_sel | m_ctl[3];
      pend = |(cond & m_en[2:0]) | (m_en[3] & (m_ddsr | m_teri));
      e.req   = req;
      e.dtr_n = ~m_ctl[0];
      e.rts_n = ~m_ctl[1];
      e.oe    = oe;
      e.irq   = oe & pend;
      e.rx    = m_ctl[4] ? tx : rx_pin;
      case (a)
         3'd1:    e.rd = {4'b0, m_en};
         3'd4:    e.rd = {3'b0, m_ctl};
         3'd6:    e.rd = {2'b0, m_ri_lvl(), m_dsr_lvl(), 2'b0, m_teri, m_ddsr};
         default: e.rd = 8'h00;
      endcase
      sb_q.push_back(e);
      wait (sb_q.size() == 0);
   endtask

   task automatic cmp(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // monitor
   initial begin
      forever begin
         exp_t e;
         wait (sb_q.size() != 0);
         @(negedge clk);
         e = sb_q.pop_front();
         cmp(e.req, "dtr_n", {7'b0, dtr_n},   {7'b0, e.dtr_n});
         cmp(e.req, "rts_n", {7'b0, rts_n},   {7'b0, e.rts_n});
         cmp(e.req, "irq_oe", {7'b0, irq_oe}, {7'b0, e.oe});
         cmp(e.req, "irq",   {7'b0, irq},     {7'b0, e.irq});
         cmp(e.req, "rx_core", {7'b0, rx_core}, {7'b0, e.rx});
         cmp(e.req, "rdata", rdata, e.rd);
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      settle(4);
      rst = 1'b0;
      settle(2);
      // R6 reset state
      expect_at("R6", 3'd4);
      expect_at("R6", 3'd1);
      expect_at("R6", 3'd6);

      // R1 terminal-ready
      bus_write(3'd4, 8'h01); expect_at("R1", 3'd4);
      bus_write(3'd4, 8'h00); expect_at("R1", 3'd4);
      // R2 request-to-send
      bus_write(3'd4, 8'h02); expect_at("R2", 3'd4);

      // R3 write held low has no effect yet
      @(negedge clk);
      addr = 3'd4; wdata = 8'h03; wr_n = 1'b0;
      settle(8);
      expect_at("R3", 3'd4);
      @(negedge clk);
      addr = 3'd4; wr_n = 1'b1;
      settle(8);
      m_ctl = 5'h03;
      track();
      expect_at("R3", 3'd4);
      bus_write(3'd2, 8'hFF); expect_at("R3", 3'd4);
      bus_write(3'd4, 8'h00);

      // R4 / R5 interrupt gating
      bus_write(3'd1, 8'h01);
      @(negedge clk); cond = 3'b001;
      expect_at("R4", 3'd1);
      @(negedge clk); int_sel = 1'b1;
      expect_at("R5", 3'd1);
      @(negedge clk); int_sel = 1'b0;
      bus_write(3'd4, 8'h08); expect_at("R5", 3'd4);
      @(negedge clk); cond = 3'b010;
      expect_at("R4", 3'd1);
      bus_write(3'd1, 8'h02); expect_at("R4", 3'd1);
      @(negedge clk); cond = 3'b100;
      expect_at("R4", 3'd1);
      bus_write(3'd1, 8'h04); expect_at("R4", 3'd1);
      @(negedge clk); cond = 3'b000;
      expect_at("R4", 3'd1);

      // R8 / R9 / R10 modem sensing
      bus_write(3'd1, 8'h08);
      pins(1'b0, 1'b1); expect_at("R10", 3'd6);
      settle(10);       expect_at("R9", 3'd6);
      stat_read();      expect_at("R9", 3'd6);
      pins(1'b0, 1'b0); expect_at("R9", 3'd6);
      pins(1'b0, 1'b1); expect_at("R9", 3'd6);
      expect_at("R10", 3'd1);
      stat_read();      expect_at("R8", 3'd6);

      // R7 / R8 loopback
      bus_write(3'd4, 8'h18); expect_at("R8", 3'd6);
      stat_read();
      @(negedge clk); tx = 1'b1; rx_pin = 1'b0;
      expect_at("R7", 3'd4);
      @(negedge clk); tx = 1'b0; rx_pin = 1'b1;
      expect_at("R7", 3'd4);
      pins(1'b1, 1'b0); expect_at("R8", 3'd6);
      bus_write(3'd4, 8'h1D); expect_at("R8", 3'd6);
      stat_read();
      bus_write(3'd4, 8'h18); expect_at("R9", 3'd6);
      stat_read();
      bus_write(3'd4, 8'h00); expect_at("R7", 3'd6);
      @(negedge clk); tx = 1'b1;
      expect_at("R7", 3'd4);

      finish_run();
   end
endmodule